// File: doc/BRIEF.md
# Auxiliary-Channel Transaction Engine

The engine runs one request/reply exchange on a byte-oriented auxiliary channel. The host first loads a command: a four-bit request code, a 20-bit target address and a message size of 0 to 16 bytes. For writes, it also pushes the payload into a small data FIFO. The host then pulses GO. The engine frames a header from the command fields and streams the header and any payload out on a valid/ready byte port. It then accepts reply bytes on a second valid/ready port until the far end marks the last byte, or until a reply timer runs out.

Completion, error flags and the received byte count are gathered in one status word. The upper nibble of the first reply byte is presented on its own as the reply code. The remaining reply bytes are read one at a time through a read port that advances on a strobe. Line coding, pad control and retries belong outside the block.

Top module: `aux_xact_engine`

## Requirements
- R1: After reset, `status` is zero, `tx_valid` is low and `rx_ready` is low.
- R2: The header starts with three bytes. The first is {request code, address[19:16]}, the second is address[15:8] and the third is address[7:0].
- R3: For a nonzero size, a fourth header byte equal to size minus one follows the address bytes. For size zero, only the three address bytes are sent.
- R4: Request codes with bit 0 clear are writes. A write appends exactly `size` FIFO bytes, in the order they were pushed, after the header. Read codes send the header only. The frame therefore holds 3 + (size>0) + (write ? size : 0) bytes, at most 20.
- R5: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` does not change on the next cycle.
- R6: The accepted codes are 0000, 0001, 0100, 0101, 1000 and 1001 (bit 2 marks an I2C middle-of-transaction request). A GO with any other code, or with a size above 16, sends no byte. Instead, the edge that samples GO sets status bit 0 (DONE) and bit 5 (bad request).
- R7: `rx_ready` is high only while a reply is awaited, and never together with `tx_valid`. Status bit 1 is high while a transaction is in progress. Every accepted reply byte is counted in status[28:24]. DONE is set by the byte that carries `rx_last`.
- R8: `reply_code` shows the upper nibble of the first reply byte. `rd_data` shows the reply payload bytes in arrival order, and each `rd_next` pulse advances to the next byte.
- R9: If `rx_last` has not arrived TIMEOUT_US microseconds of core clock after the last transmitted byte, the engine sets DONE and status bit 2 (timeout), and the byte count reads zero.
- R10: A reply byte accepted with `rx_err` high sets status bit 3. A reply byte beyond 17 is dropped and not counted, and it sets status bit 4 (overflow).
- R11: `done_ack` clears DONE and leaves the count and flags as they are. GO clears DONE, all flags and the count.
- R12: While a transaction is in progress, `cmd_we` and `go` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Load the command fields |
| cmd_req | input | 4 | Request code |
| cmd_addr | input | 20 | Target address |
| cmd_size | input | 5 | Message size in bytes |
| fifo_we | input | 1 | Push one payload byte |
| fifo_wdata | input | 8 | Payload byte |
| go | input | 1 | Start the transaction |
| done_ack | input | 1 | Clear DONE |
| status | output | 32 | Flags in bits 5:0, reply count in bits 28:24 |
| reply_code | output | 4 | Upper nibble of the first reply byte |
| rd_next | input | 1 | Advance the reply payload read pointer |
| rd_data | output | 8 | Current reply payload byte |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Line accepts the transmit byte |
| rx_valid | input | 1 | Reply byte valid |
| rx_data | input | 8 | Reply byte |
| rx_last | input | 1 | Marks the final reply byte |
| rx_err | input | 1 | Receive error on this byte |
| rx_ready | output | 1 | Engine accepts a reply byte |

## Verification
The properties take for granted that the line side obeys the handshake. In particular, they assume nothing drives reply bytes that the engine has not asked for. They also assume that `done_ack` and `go` arrive as single-cycle pulses from an idle host. The bench drives reply bytes only after it has seen `rx_ready` high, and it raises `tx_ready` either steadily or on alternate cycles. It loads the payload FIFO only between transactions and never with more bytes than the size it programs. The only busy-time writes and GO pulses it issues are the deliberate ones that test R12.

// File: rtl/aux_xact_engine.sv
module aux_xact_engine #(
  parameter int CLK_HZ     = 100_000_000,
  parameter int TIMEOUT_US = 400,
  parameter int MAX_SIZE   = 16
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_we,
  input  logic [3:0]  cmd_req,
  input  logic [19:0] cmd_addr,
  input  logic [4:0]  cmd_size,
  input  logic        fifo_we,
  input  logic [7:0]  fifo_wdata,
  input  logic        go,
  input  logic        done_ack,
  output logic [31:0] status,
  output logic [3:0]  reply_code,
  input  logic        rd_next,
  output logic [7:0]  rd_data,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  input  logic        tx_ready,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_last,
  input  logic        rx_err,
  output logic        rx_ready
);
  localparam int TO_CYC = (CLK_HZ / 1_000_000) * TIMEOUT_US;
  localparam int TW     = $clog2(TO_CYC + 1);
  localparam int PW     = $clog2(MAX_SIZE);
  localparam int FCW    = $clog2(MAX_SIZE + 1);
  localparam int RD     = MAX_SIZE + 1;
  localparam int CW     = $clog2(RD + 1);

  typedef enum logic [1:0] {S_IDLE, S_TX, S_RX} state_t;
  state_t st;

  logic [3:0]  req;
  logic [19:0] addr;
  logic [4:0]  size;
  logic [5:0]  idx;
  logic [7:0]  fifo [MAX_SIZE];
  logic [PW-1:0] wp, rp;
  logic [FCW-1:0] fcnt;
  logic [7:0]  rbuf [RD];
  logic [CW-1:0] rcnt, rptr;
  logic [TW-1:0] tmr;
  logic done, tmo, rxe, ovf, bad;

  wire       is_wr   = ~req[0];
  wire       code_ok = ~req[1] & ~(req[3] & req[2]);
  wire       size_ok = int'(size) <= MAX_SIZE;
  wire [5:0] total   = 6'd3 + {5'd0, size != 5'd0} + (is_wr ? {1'b0, size} : 6'd0);
  wire       idle    = st == S_IDLE;
  wire       tx_fire = tx_valid & tx_ready;
  wire       last_tx = tx_fire && idx == total - 6'd1;
  wire       rx_fire = rx_valid & rx_ready;
  wire       rx_end  = rx_fire & rx_last;
  wire       expire  = st == S_RX && !rx_end && tmr == TW'(TO_CYC - 1);
  wire       reject  = idle && go && !(code_ok && size_ok);
  wire       flush   = rx_end || expire || reject;
  wire       push    = fifo_we && idle && fcnt != FCW'(MAX_SIZE);
  wire       pop     = tx_fire && idx >= 6'd4;
  wire [CW-1:0] rsel = rptr + 1'b1;

  assign tx_valid   = st == S_TX;
  assign rx_ready   = st == S_RX;
  assign status     = {3'b000, 5'(rcnt), 18'd0, bad, ovf, rxe, tmo, ~idle, done};
  assign reply_code = (rcnt != '0) ? rbuf[0][7:4] : 4'h0;
  assign rd_data    = (rsel < rcnt) ? rbuf[rsel] : 8'h00;

  always_comb begin
    case (idx)
      6'd0:    tx_data = {req, addr[19:16]};
      6'd1:    tx_data = addr[15:8];
      6'd2:    tx_data = addr[7:0];
      6'd3:    tx_data = {3'b000, size - 5'd1};
      default: tx_data = fifo[rp];
    endcase
  end

  always_ff @(posedge clk) if (push) fifo[wp] <= fifo_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; fcnt <= '0;
    end else if (flush) begin
      wp <= '0; rp <= '0; fcnt <= '0;
    end else begin
      if (push) wp <= (wp == PW'(MAX_SIZE - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == PW'(MAX_SIZE - 1)) ? '0 : rp + 1'b1;
      fcnt <= fcnt + FCW'(push) - FCW'(pop);
    end
  end

  always_ff @(posedge clk) if (rx_fire && rcnt < CW'(RD)) rbuf[rcnt] <= rx_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; req <= '0; addr <= '0; size <= '0; idx <= '0; tmr <= '0;
      rcnt <= '0; rptr <= '0;
      done <= 1'b0; tmo <= 1'b0; rxe <= 1'b0; ovf <= 1'b0; bad <= 1'b0;
    end else begin
      if (done_ack) done <= 1'b0;
      if (rd_next && rsel < rcnt) rptr <= rsel;
      case (st)
        S_IDLE: begin
          if (cmd_we) begin
            req <= cmd_req; addr <= cmd_addr; size <= cmd_size;
          end
          if (go) begin
            rcnt <= '0; rptr <= '0;
            tmo <= 1'b0; rxe <= 1'b0; ovf <= 1'b0; bad <= 1'b0; done <= 1'b0;
            if (reject) begin
              bad  <= 1'b1;
              done <= 1'b1;
            end else begin
              st  <= S_TX;
              idx <= '0;
            end
          end
        end
        S_TX: begin
          if (tx_fire) idx <= idx + 6'd1;
          if (last_tx) begin
            st  <= S_RX;
            tmr <= '0;
          end
        end
        S_RX: begin
          if (rx_fire) begin
            if (rx_err) rxe <= 1'b1;
            if (rcnt < CW'(RD)) rcnt <= rcnt + 1'b1;
            else                ovf  <= 1'b1;
          end
          if (rx_end) begin
            done <= 1'b1;
            st   <= S_IDLE;
          end else if (expire) begin
            tmo  <= 1'b1;
            done <= 1'b1;
            rcnt <= '0;
            st   <= S_IDLE;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module aux_xact_engine_chk #(
  parameter int MAX_SIZE = 16
)(
  input logic        clk,
  input logic        rst_n,
  input logic        go,
  input logic        done_ack,
  input logic [31:0] status,
  input logic        tx_valid,
  input logic [7:0]  tx_data,
  input logic        tx_ready,
  input logic        rx_ready
);
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_valid && rx_ready));

  p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !status[1] |-> !tx_valid && !rx_ready);

  p_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_ack && !status[1] && !go |=> !status[0]);

  p_bad_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[5]) |-> status[0] && !tx_valid);

  p_tmo_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[2]) |-> status[0] && status[28:24] == 5'd0);

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    int'(status[28:24]) <= MAX_SIZE + 1);
endmodule

bind aux_xact_engine aux_xact_engine_chk #(.MAX_SIZE(MAX_SIZE)) u_chk (
  .clk(clk), .rst_n(rst_n), .go(go), .done_ack(done_ack), .status(status),
  .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready), .rx_ready(rx_ready)
);

// File: tb/aux_xact_engine_test.sv
module aux_xact_engine_test;
  localparam int TO = 100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_we = 0, fifo_we = 0, go = 0, done_ack = 0, rd_next = 0;
  logic [3:0] cmd_req = 0;
  logic [19:0] cmd_addr = 0;
  logic [4:0] cmd_size = 0;
  logic [7:0] fifo_wdata = 0, rx_data = 0;
  logic tx_ready = 1, rx_valid = 0, rx_last = 0, rx_err = 0;
  logic [31:0] status;
  logic [3:0] reply_code;
  logic [7:0] rd_data, tx_data;
  logic tx_valid, rx_ready;

  aux_xact_engine #(.CLK_HZ(1_000_000), .TIMEOUT_US(TO), .MAX_SIZE(16)) uut (.*);

  always #10 clk = ~clk;

  int n_chk = 0, n_err = 0;
  logic [7:0] exp_q[$];
  logic [7:0] rep [0:17];
  logic       rep_e [0:17];
  bit stall = 0;
  logic [3:0] tick = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    #1;
    tick <= tick + 1'b1;
    tx_ready = stall ? tick[0] : 1'b1;
  end

  logic       prev_stall = 0;
  logic [7:0] prev_data = 0;
  always @(negedge clk) begin
    if (prev_stall) check(tx_valid && tx_data == prev_data, "R5 held byte", {23'd0, tx_valid, tx_data}, {24'd1, prev_data});
    prev_stall = tx_valid && !tx_ready;
    prev_data  = tx_data;
    if (tx_valid && tx_ready) begin
      if (exp_q.size() == 0) check(1'b0, "R4/R6 unexpected byte", {24'd0, tx_data}, 32'h0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(tx_data == e, "R2/R3/R4 frame byte", {24'd0, tx_data}, {24'd0, e});
      end
    end
  end

  task automatic load_cmd(input logic [3:0] r, input logic [19:0] a, input logic [4:0] s);
    @(posedge clk); #1 cmd_we = 1; cmd_req = r; cmd_addr = a; cmd_size = s;
    @(posedge clk); #1 cmd_we = 0;
  endtask

  task automatic expect_hdr(input logic [3:0] r, input logic [19:0] a, input logic [4:0] s);
    exp_q.push_back({r, a[19:16]});
    exp_q.push_back(a[15:8]);
    exp_q.push_back(a[7:0]);
    if (s != 0) exp_q.push_back({3'b0, s - 5'd1});
  endtask

  task automatic push_byte(input logic [7:0] b);
    @(posedge clk); #1 fifo_we = 1; fifo_wdata = b;
    @(posedge clk); #1 fifo_we = 0;
    exp_q.push_back(b);
  endtask

  task automatic pulse_go();
    @(posedge clk); #1 go = 1;
    @(posedge clk); #1 go = 0;
  endtask

  task automatic ack();
    @(posedge clk); #1 done_ack = 1;
    @(posedge clk); #1 done_ack = 0;
  endtask

  task automatic wait_rx();
    @(negedge clk);
    while (!rx_ready) @(negedge clk);
  endtask

  task automatic reply(input int n);
    wait_rx();
    check(exp_q.size() == 0, "R4 frame fully sent", exp_q.size(), 0);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 rx_valid = 1; rx_data = rep[i]; rx_err = rep_e[i]; rx_last = (i == n - 1);
    end
    @(posedge clk); #1 rx_valid = 0; rx_last = 0; rx_err = 0;
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 18; i++) begin rep[i] = 8'(i * 7 + 3); rep_e[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(status == 0 && !tx_valid && !rx_ready, "R1 reset state", status, 0);
    #1 rst_n = 1;

    // native write, 2 bytes
    load_cmd(4'h8, 20'h5A3C1, 5'd2);
    expect_hdr(4'h8, 20'h5A3C1, 5'd2);
    push_byte(8'hDE); push_byte(8'hAD);
    ack(); pulse_go();
    rep[0] = 8'h00;
    reply(1);
    check(status == 32'h0100_0001, "R7 write done", status, 32'h0100_0001);
    check(reply_code == 4'h0, "R8 write reply code", reply_code, 0);
    ack(); @(negedge clk);
    check(status == 32'h0100_0000, "R11 ack clears done only", status, 32'h0100_0000);

    // native read, 4 bytes, stalled line, busy-time intrusion
    stall = 1;
    load_cmd(4'h9, 20'h00102, 5'd4);
    expect_hdr(4'h9, 20'h00102, 5'd4);
    pulse_go();
    @(posedge clk); #1 cmd_we = 1; cmd_req = 4'h1; cmd_addr = 20'hFFFFF; cmd_size = 5'd9; go = 1;
    @(posedge clk); #1 cmd_we = 0; go = 0;
    rep[0] = 8'hA0; rep[1] = 8'h11; rep[2] = 8'h22; rep[3] = 8'h33; rep[4] = 8'h44;
    reply(5);
    check(status == 32'h0500_0001, "R7 read count", status, 32'h0500_0001);
    check(reply_code == 4'hA, "R8 reply code", reply_code, 4'hA);
    for (int i = 1; i <= 4; i++) begin
      check(rd_data == rep[i], "R8 payload byte", rd_data, rep[i]);
      @(posedge clk); #1 rd_next = 1;
      @(posedge clk); #1 rd_next = 0;
      @(negedge clk);
    end
    ack();
    expect_hdr(4'h9, 20'h00102, 5'd4);
    pulse_go();
    rep[0] = 8'h00;
    reply(1);
    check(status == 32'h0100_0001, "R12 command kept through busy writes", status, 32'h0100_0001);
    stall = 0;

    // I2C write with MOT, zero size
    ack();
    load_cmd(4'h4, 20'h00050, 5'd0);
    expect_hdr(4'h4, 20'h00050, 5'd0);
    pulse_go();
    reply(1);
    check(status == 32'h0100_0001, "R3 address-only done", status, 32'h0100_0001);

    // I2C write 16 bytes, stalled
    ack(); stall = 1;
    load_cmd(4'h0, 20'hFFFFF, 5'd16);
    expect_hdr(4'h0, 20'hFFFFF, 5'd16);
    for (int i = 0; i < 16; i++) push_byte(8'(i * 3 + 1));
    pulse_go();
    reply(1);
    check(status == 32'h0100_0001, "R4 max frame done", status, 32'h0100_0001);
    stall = 0;

    // invalid code, oversize, native with MOT bit
    ack();
    load_cmd(4'h2, 20'h00001, 5'd1);
    pulse_go(); @(negedge clk);
    check(status == 32'h0000_0021, "R6 bad code", status, 32'h21);
    ack();
    load_cmd(4'h8, 20'h00001, 5'd17);
    pulse_go(); @(negedge clk);
    check(status == 32'h0000_0021, "R6 oversize", status, 32'h21);
    ack();
    load_cmd(4'hC, 20'h00001, 5'd1);
    pulse_go(); @(negedge clk);
    check(status == 32'h0000_0021, "R6 native with MOT", status, 32'h21);

    // timeout
    ack();
    load_cmd(4'h9, 20'h00001, 5'd1);
    expect_hdr(4'h9, 20'h00001, 5'd1);
    pulse_go(); @(negedge clk);
    check(status == 32'h0000_0002, "R11 go clears flags", status, 32'h2);
    wait_rx();
    repeat (TO - 5) @(negedge clk);
    check(status[0] == 1'b0, "R9 not yet expired", status, 0);
    repeat (10) @(negedge clk);
    check(status == 32'h0000_0005, "R9 timeout", status, 32'h5);

    // receive error
    ack();
    load_cmd(4'h1, 20'h0000A, 5'd2);
    expect_hdr(4'h1, 20'h0000A, 5'd2);
    pulse_go();
    rep_e[1] = 1;
    reply(3);
    rep_e[1] = 0;
    check(status == 32'h0300_0009, "R10 rx error flag", status, 32'h0300_0009);

    // overflow
    ack();
    load_cmd(4'h9, 20'h00000, 5'd16);
    expect_hdr(4'h9, 20'h00000, 5'd16);
    pulse_go();
    reply(18);
    check(status == 32'h1100_0011, "R10 overflow", status, 32'h1100_0011);

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R4 queue drained", exp_q.size(), 0);
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    summary();
  end
endmodule